// File: doc/BRIEF.md
# UART Flag and FIFO Status Controller

This block keeps the receive and transmit status flags of a FIFO-based UART and combines them into one interrupt line. The processor side sees three registers. A control register holds the interrupt enables and the tuning fields. An action register accepts write-only command bits. A status register is read-only. The UART side of the block takes one-cycle event pulses from the receiver, a bit-time tick from the baud generator, and the current fill counts of the receive and transmit FIFOs. The FIFO storage and the serial shifters sit outside this block.

Every error flag has its own set and clear action bits, and the receiver's error events set it as well. The receive-ready flag is not set directly by an arriving character. A programmable number of bit times must pass after the first character of a non-empty run, so the processor can collect a burst in one interrupt. The transmit-ready flag is raised when the transmit FIFO fill drops to a programmable threshold or below. A receive character is only presented after an explicit pull action, so the action register also drives the FIFO pull and clear strobes.

Top module: `uart_flag_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, the control register reads zero, status bits [5:0] read zero and `irq` is low.
- R2: A write to the action register with bit 0, 1, 2, 3 or 4 set clears, at the next clock edge, receive-ready, overrun, break, framing error or parity error respectively. In status these flags sit at bits 0, 2, 3, 4 and 5.
- R3: Action bits 5 to 9 set the same five flags in the same order at the next edge. When the set bit and the clear bit of one flag are written together, the flag ends up set.
- R4: A pulse on `ev_overrun`, `ev_break`, `ev_frame` or `ev_parity` sets the matching flag at the next edge, even if the clear bit for that flag is written in the same cycle.
- R5: Action bits 10, 11 and 12 drive `rx_pull`, `rx_clear` and `tx_clear` in the same cycle as the write. No strobe is active in a cycle without an action write.
- R6: Transmit-ready (status bit 1) becomes set at the edge after the transmit fill count enters the range at or below the threshold in control bits [25:22]. It becomes clear at the edge after a cycle in which the count is above the threshold. Action bit 13 clears it and action bit 14 sets it, and set wins. After a software clear, the flag stays low while the count stays in range.
- R7: Receive-ready becomes set only after D bit ticks have passed since the `ev_rx_done` pulse that started a non-empty run, where D is control bits [21:14]. With D ticks counted, it is set one edge after the last tick's count lands. With D = 0, it is set two edges after the pulse.
- R8: The receive-ready timer fires once per run. It restarts only after the receive fill count reads zero, so a new run needs D fresh ticks.
- R9: Status bits [10:6] show the receive fill count and bits [15:11] show the transmit fill count, in the same cycle as the count inputs.
- R10: `irq` is high exactly when some flag is set and its enable bit is set. Control bits 0 to 5 enable receive-ready, overrun, break, framing error, parity error and transmit-ready, in that order.
- R11: A control write is readable on `ctrl_q` from the next edge on, with all 26 bits kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_wdata | input | 26 | Control register write data |
| ctrl_q | output | 26 | Control register contents |
| act_we | input | 1 | Action register write strobe |
| act_wdata | input | 15 | Action command bits |
| status_q | output | 16 | Status register |
| ev_rx_done | input | 1 | Receiver finished a character |
| ev_overrun | input | 1 | Receiver overrun event |
| ev_break | input | 1 | Break detected |
| ev_frame | input | 1 | Framing error event |
| ev_parity | input | 1 | Parity error event |
| bit_tick | input | 1 | One pulse per serial bit time |
| rx_count | input | 5 | Receive FIFO fill count |
| tx_count | input | 5 | Transmit FIFO fill count |
| rx_pull | output | 1 | Pop one receive character into the data register |
| rx_clear | output | 1 | Flush the receive FIFO |
| tx_clear | output | 1 | Flush the transmit FIFO |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked by the assertions on every cycle:
- a set action or receiver event wins over a clear;
- a lone clear takes effect;
- no strobe fires without an action write;
- transmit-ready drops when the fill count is above the threshold;
- the interrupt line agrees with the enabled flags.

Other behaviour needs an ordered history, so only the bench's scenarios can show it. This covers the receive-ready delay measured in ticks, the timer restart after the receive FIFO drains, transmit-ready being raised only on entry into the threshold range, and the field positions of the control and status registers.

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl #(
  parameter int CNT_W = 5,
  parameter int DLY_W = 8,
  parameter int THR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctrl_we,
  input  logic [14+DLY_W+THR_W-1:0]    ctrl_wdata,
  output logic [14+DLY_W+THR_W-1:0]    ctrl_q,
  input  logic                         act_we,
  input  logic [14:0]                  act_wdata,
  output logic [6+2*CNT_W-1:0]         status_q,
  input  logic                         ev_rx_done,
  input  logic                         ev_overrun,
  input  logic                         ev_break,
  input  logic                         ev_frame,
  input  logic                         ev_parity,
  input  logic                         bit_tick,
  input  logic [CNT_W-1:0]             rx_count,
  input  logic [CNT_W-1:0]             tx_count,
  output logic                         rx_pull,
  output logic                         rx_clear,
  output logic                         tx_clear,
  output logic                         irq
);
  localparam int CTRL_W  = 14 + DLY_W + THR_W;
  localparam int DLY_LSB = 14;
  localparam int THR_LSB = 14 + DLY_W;

  logic [CTRL_W-1:0] ctrl;
  logic [4:0]        rxf;      // pe, fe, brk, oe, rrdy
  logic              trdy;
  logic              in_range_q;
  logic              started, fired;
  logic [DLY_W-1:0]  tcnt;

  wire [DLY_W-1:0] dly = ctrl[DLY_LSB +: DLY_W];
  wire [THR_W-1:0] thr = ctrl[THR_LSB +: THR_W];

  // receive-ready delay timer
  wire fire = started && !fired && (tcnt == dly);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      fired   <= 1'b0;
      tcnt    <= '0;
    end else if (!started) begin
      started <= ev_rx_done;
      fired   <= 1'b0;
      tcnt    <= '0;
    end else if (rx_count == '0 && !ev_rx_done) begin
      started <= 1'b0;
    end else if (fire) begin
      fired <= 1'b1;
    end else if (bit_tick && !fired) begin
      tcnt <= tcnt + 1'b1;
    end
  end

  // receive-side flags
  wire [4:0] clr_sw = act_we ? act_wdata[4:0] : 5'b0;
  wire [4:0] set_sw = act_we ? act_wdata[9:5] : 5'b0;
  wire [4:0] set_hw = {ev_parity, ev_frame, ev_break, ev_overrun, fire};

  always_ff @(posedge clk) begin
    if (!rst_n) rxf <= '0;
    else        rxf <= set_sw | set_hw | (rxf & ~clr_sw);
  end

  // transmit-ready
  wire in_range   = ({1'b0, tx_count} <= {{(CNT_W+1-THR_W){1'b0}}, thr});
  wire trdy_set   = (act_we && act_wdata[14]) || (in_range && !in_range_q);
  wire trdy_clr   = (act_we && act_wdata[13]) || !in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trdy       <= 1'b0;
      in_range_q <= 1'b0;
    end else begin
      trdy       <= trdy_set || (trdy && !trdy_clr);
      in_range_q <= in_range;
    end
  end

  // control register
  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_we) ctrl <= ctrl_wdata;
  end

  assign ctrl_q   = ctrl;
  assign status_q = {tx_count, rx_count, rxf[4:1], trdy, rxf[0]};
  assign rx_pull  = act_we && act_wdata[10];
  assign rx_clear = act_we && act_wdata[11];
  assign tx_clear = act_we && act_wdata[12];
  assign irq      = |({trdy, rxf} & ctrl[5:0]);

  // assertions
  assert_sw_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_we && act_wdata[6]) |=> status_q[2]);

  assert_sw_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_we && act_wdata[1] && !act_wdata[6] && !ev_overrun) |=> !status_q[2]);

  assert_hw_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_break |=> status_q[3]);

  assert_no_idle_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !act_we |-> !(rx_pull || rx_clear || tx_clear));

  assert_trdy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, tx_count} > {{(CNT_W+1-THR_W){1'b0}}, ctrl_q[THR_LSB +: THR_W]})
      && !(act_we && act_wdata[14])) |=> !status_q[1]);

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[2] && ctrl_q[1]) |-> irq);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[5:0] == 6'b0) |-> !irq);
endmodule

// File: tb/uart_flag_ctrl_tb.sv
`timescale 1ns/100ps
module uart_flag_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_we;
  logic [25:0] ctrl_wdata;
  logic [25:0] ctrl_q;
  logic        act_we;
  logic [14:0] act_wdata;
  logic [15:0] status_q;
  logic        ev_rx_done, ev_overrun, ev_break, ev_frame, ev_parity, bit_tick;
  logic [4:0]  rx_count, tx_count;
  logic        rx_pull, rx_clear, tx_clear, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_flag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .act_we(act_we), .act_wdata(act_wdata), .status_q(status_q),
    .ev_rx_done(ev_rx_done), .ev_overrun(ev_overrun), .ev_break(ev_break),
    .ev_frame(ev_frame), .ev_parity(ev_parity), .bit_tick(bit_tick),
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_pull(rx_pull), .rx_clear(rx_clear), .tx_clear(tx_clear), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [25:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic act(input logic [14:0] v);
    act_we = 1'b1; act_wdata = v;
    @(negedge clk);
    act_we = 1'b0; act_wdata = '0;
  endtask

  task automatic tick;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cyc(3);
    chk("R1 ctrl in reset", ctrl_q, 0);
    chk("R1 flags in reset", status_q[5:0], 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 error flags after reset", {status_q[5:2], status_q[0]}, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R6 trdy raised by empty tx fifo", status_q[1], 1);
  endtask

  task automatic t_ctrl;
    wr_ctrl(26'h2ABCDEF);
    chk("R11 ctrl readback", ctrl_q, 26'h2ABCDEF);
    wr_ctrl(26'h0);
    chk("R11 ctrl cleared", ctrl_q, 0);
  endtask

  task automatic t_sw_flags;
    act(15'h03E0);
    chk("R3 set all five", {status_q[5:2], status_q[0]}, 5'h1F);
    act(15'h0002);
    chk("R2 clear overrun only", {status_q[5:2], status_q[0]}, 5'b11101);
    act(15'h001D);
    chk("R2 clear the rest", {status_q[5:2], status_q[0]}, 0);
    act(15'h0210);
    chk("R3 set wins over clear (parity)", status_q[5], 1);
    act(15'h0010);
    chk("R2 parity cleared", status_q[5], 0);
  endtask

  task automatic t_hw_events;
    ev_overrun = 1; ev_frame = 1;
    @(negedge clk);
    ev_overrun = 0; ev_frame = 0;
    chk("R4 overrun and frame set", status_q[5:2], 4'b0101);
    ev_break = 1; ev_parity = 1;
    act_we = 1; act_wdata = 15'h0014;
    @(negedge clk);
    ev_break = 0; ev_parity = 0; act_we = 0; act_wdata = 0;
    chk("R4 events win over clear", status_q[5:2], 4'b1111);
    act(15'h001F);
    chk("R2 cleared after events", status_q[5:2], 0);
  endtask

  task automatic t_strobes;
    act_we = 1; act_wdata = 15'h0400;
    #1;
    chk("R5 pull strobe", {rx_pull, rx_clear, tx_clear}, 3'b100);
    act_wdata = 15'h1800;
    #1;
    chk("R5 clear strobes", {rx_pull, rx_clear, tx_clear}, 3'b011);
    act_we = 0;
    #1;
    chk("R5 no strobe without write", {rx_pull, rx_clear, tx_clear}, 0);
    act_wdata = 0;
    @(negedge clk);
  endtask

  task automatic t_trdy;
    wr_ctrl(26'h2 << 22);
    tx_count = 5'd3;
    cyc(1);
    chk("R6 above threshold clears", status_q[1], 0);
    tx_count = 5'd2;
    cyc(1);
    chk("R6 entering threshold sets", status_q[1], 1);
    act(15'h2000);
    chk("R6 software clear", status_q[1], 0);
    tx_count = 5'd1;
    cyc(2);
    chk("R6 stays clear while in range", status_q[1], 0);
    tx_count = 5'd5;
    cyc(1);
    tx_count = 5'd0;
    cyc(1);
    chk("R6 re-entry sets", status_q[1], 1);
    act(15'h6000);
    chk("R6 set wins over clear", status_q[1], 1);
    wr_ctrl(26'h0);
    tx_count = 5'd0;
  endtask

  task automatic t_rrdy;
    wr_ctrl(26'd3 << 14);
    rx_count = 5'd0;
    cyc(1);
    ev_rx_done = 1; rx_count = 5'd1;
    @(negedge clk);
    ev_rx_done = 0;
    tick();
    tick();
    chk("R7 not ready after two ticks", status_q[0], 0);
    bit_tick = 1; @(negedge clk); bit_tick = 0;
    chk("R7 not ready on count landing", status_q[0], 0);
    @(negedge clk);
    chk("R7 ready after three ticks", status_q[0], 1);
    act(15'h0001);
    tick(); tick(); tick(); tick();
    chk("R8 fires once per run", status_q[0], 0);
    rx_count = 5'd0;
    cyc(1);
    ev_rx_done = 1; rx_count = 5'd1;
    @(negedge clk);
    ev_rx_done = 0;
    tick(); tick();
    chk("R8 restarted timer needs fresh ticks", status_q[0], 0);
    tick();
    @(negedge clk);
    chk("R8 ready again after restart", status_q[0], 1);
    act(15'h0001);
    wr_ctrl(26'h0);
    rx_count = 5'd0;
    cyc(1);
    ev_rx_done = 1; rx_count = 5'd2;
    @(negedge clk);
    ev_rx_done = 0;
    chk("R7 zero delay, one edge", status_q[0], 0);
    @(negedge clk);
    chk("R7 zero delay, two edges", status_q[0], 1);
    act(15'h0001);
    rx_count = 5'd0;
    cyc(1);
  endtask

  task automatic t_counts;
    rx_count = 5'd16; tx_count = 5'd9;
    #1;
    chk("R9 rx count field", status_q[10:6], 16);
    chk("R9 tx count field", status_q[15:11], 9);
    rx_count = 5'd0; tx_count = 5'd0;
    cyc(2);
  endtask

  task automatic t_irq;
    act(15'h2000);
    chk("R10 irq low with no enables", irq, 0);
    wr_ctrl(26'h02);
    chk("R10 enabled but no flag", irq, 0);
    act(15'h0040);
    chk("R10 overrun with enable", irq, 1);
    wr_ctrl(26'h3D);
    chk("R10 overrun masked", irq, 0);
    act(15'h4000);
    chk("R10 trdy enabled", irq, 1);
    act(15'h2000);
    wr_ctrl(26'h10);
    act(15'h0200);
    chk("R10 parity enable bit 4", irq, 1);
    act(15'h0010);
    chk("R10 parity cleared", irq, 0);
    wr_ctrl(26'h0);
  endtask

  initial begin
    rst_n = 0; ctrl_we = 0; ctrl_wdata = 0; act_we = 0; act_wdata = 0;
    ev_rx_done = 0; ev_overrun = 0; ev_break = 0; ev_frame = 0; ev_parity = 0;
    bit_tick = 0; rx_count = 0; tx_count = 0;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_sw_flags();
    t_hw_events();
    t_strobes();
    t_trdy();
    t_rrdy();
    t_counts();
    t_irq();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule